// File: doc/BRIEF.md
# Smart Card Initial Character Checker

This block watches the contact side of a smart card interface: the card reset line, the card clock, the supply line and the bidirectional data line. The data line is seen as the AND of the terminal-side and card-side lines. All of these signals are asynchronous to the system clock, and the block samples them in that clock. It reports when the interface is powered and clocked. After reset release it counts card clock rising edges. From that count it decides whether the first answer character started too soon or never arrived in time.

A separate character receiver delivers the first received byte together with a one-cycle strobe. The byte is raw: bit 0 is the first data bit after the start bit, and each bit is the line level as sampled, with high read as 1. The block classifies that byte. It reports whether the card uses the direct convention (least significant bit first, high level is 1) or the inverse convention (most significant bit first, levels inverted), or whether the byte is not a valid initial character. Downstream logic uses the convention flag to set up its receiver for the rest of the answer.

Top module: `ts_checker`

## Requirements
- R1: `activated` rises after the supply input is high and one rising card clock edge has been seen. It falls as soon as the supply input goes low, and every other flag is cleared at the same time.
- R2: The monitored data line is the AND of `io_term` and `io_card`. A falling edge on either line while the other line is high counts as the start of the initial character.
- R3: `atr_early` is set when the first start edge after reset release comes after fewer than 400 card clock rising edges. If the start edge comes after 400 or more edges, `atr_early` stays 0.
- R4: `atr_late` is set once 40000 card clock rising edges have been counted since reset release with no initial character received. At 39999 edges it is still 0.
- R5: A raw byte of 0x3B marks the direct convention. The block sets `ts_received` to 1 and holds `inverse_conv` and `ts_error` at 0.
- R6: A raw byte of 0x03 marks the inverse convention: it reads as 0x3F once inverted and reversed. The block sets `ts_received` and `inverse_conv` to 1 and holds `ts_error` at 0.
- R7: Any other raw byte sets `ts_received` and `ts_error` to 1 and holds `inverse_conv` at 0.
- R8: Only the first byte strobed after reset release is judged. Later strobes and later start edges leave every flag unchanged.
- R9: Once the initial character has been received, the edge counter stops. Further card clock edges never set `atr_late`.
- R10: The system reset `rst_n` clears every output. A falling edge on `card_rst` clears `ts_received`, `ts_error`, `inverse_conv`, `atr_early` and `atr_late`, and leaves `activated` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_rst | input | 1 | Card reset line; a rising edge releases the card from reset |
| card_clk | input | 1 | Card clock line |
| card_vdd | input | 1 | Card supply present |
| io_term | input | 1 | Terminal-side data line |
| io_card | input | 1 | Card-side data line |
| char_done | input | 1 | One-cycle strobe from the character receiver |
| char_data | input | 8 | Raw received byte, first data bit in bit 0 |
| activated | output | 1 | Interface powered and clocked |
| ts_received | output | 1 | Initial character has been judged |
| ts_error | output | 1 | Initial character was not a valid pattern |
| atr_early | output | 1 | Answer started before 400 card clock edges |
| atr_late | output | 1 | No answer after 40000 card clock edges |
| inverse_conv | output | 1 | Card uses the inverse convention |

## Verification
The bench places the start edge at 399 and at 400 card clock edges. A design with an off-by-one compare would give the wrong early flag on one of those two runs. It also stops one edge short of the late limit and then adds the last edge. A counter that fires one edge too soon or one edge too late shows up as a wrong late flag. It sends a second character and more clock edges after a valid initial character. A design that judged every byte or kept counting would change its convention or set the late flag. Finally, it asserts card reset and drops supply while flags are set. A design that missed either clear would carry stale flags into the next session.

// File: rtl/ts_chk_pkg.sv
package ts_chk_pkg;

  typedef enum logic [1:0] {
    TS_DIRECT  = 2'd0,
    TS_INVERSE = 2'd1,
    TS_INVALID = 2'd2
  } ts_conv_e;

  localparam logic [7:0] DIRECT_PATTERN  = 8'h3B;
  localparam logic [7:0] INVERSE_PATTERN = 8'h3F;

  // Read a raw byte under the inverse convention: complement, then reverse bit order.
  function automatic logic [7:0] inverse_view(input logic [7:0] raw);
    logic [7:0] flipped;
    for (int i = 0; i < 8; i++) flipped[i] = ~raw[7-i];
    return flipped;
  endfunction

  function automatic ts_conv_e classify_ts(input logic [7:0] raw);
    if (raw == DIRECT_PATTERN) return TS_DIRECT;
    if (inverse_view(raw) == INVERSE_PATTERN) return TS_INVERSE;
    return TS_INVALID;
  endfunction

endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign sync_out[b] = chain_q[STAGES-1][b];
  end
endmodule

// File: rtl/ts_window.sv
module ts_window #(
  parameter int EARLY_LIMIT = 400,
  parameter int LATE_LIMIT  = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_s,
  input  logic cclk_s,
  input  logic crst_s,
  input  logic io_s,
  input  logic ts_rcv,
  output logic activated,
  output logic released,
  output logic clear,
  output logic atr_early,
  output logic atr_late
);
  localparam int CW = $clog2(LATE_LIMIT + 1);
  localparam logic [CW-1:0] EARLY_C = CW'(EARLY_LIMIT);
  localparam logic [CW-1:0] LATE_C  = CW'(LATE_LIMIT);

  function automatic logic before_window(input logic [CW-1:0] c);
    return c < EARLY_C;
  endfunction

  function automatic logic at_ceiling(input logic [CW-1:0] c);
    return c == LATE_C;
  endfunction

  logic cclk_q, crst_q, io_q;
  logic cclk_rise, rst_rise, rst_fall, io_fall;
  logic [CW-1:0] cnt_q;
  logic start_seen_q;

  assign cclk_rise = cclk_s & ~cclk_q;
  assign rst_rise  = crst_s & ~crst_q;
  assign rst_fall  = ~crst_s & crst_q;
  assign io_fall   = ~io_s & io_q;
  assign clear     = rst_fall | ~vdd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      crst_q <= 1'b0;
      io_q   <= 1'b0;
    end else begin
      cclk_q <= cclk_s;
      crst_q <= crst_s;
      io_q   <= io_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          activated <= 1'b0;
    else if (!vdd_s)     activated <= 1'b0;
    else if (cclk_rise)  activated <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     released <= 1'b0;
    else if (clear)                 released <= 1'b0;
    else if (rst_rise && activated) released <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (released && !ts_rcv && cclk_rise && !at_ceiling(cnt_q)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_seen_q <= 1'b0;
      atr_early    <= 1'b0;
    end else if (clear) begin
      start_seen_q <= 1'b0;
      atr_early    <= 1'b0;
    end else if (released && io_fall && !start_seen_q) begin
      start_seen_q <= 1'b1;
      atr_early    <= before_window(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       atr_late <= 1'b0;
    else if (clear)                                   atr_late <= 1'b0;
    else if (released && !ts_rcv && at_ceiling(cnt_q)) atr_late <= 1'b1;
  end

  // R3: the early flag only rises on a start edge seen after release
  a_r3_early_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atr_early) |-> $past(io_fall && released));

  // R4: the late flag implies the counter is parked at its ceiling
  a_r4_late_at_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    atr_late |-> (cnt_q == LATE_C));

  // R9: the counter stays frozen once the initial character is in
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_rcv && $past(ts_rcv)) |-> $stable(cnt_q));
endmodule

// File: rtl/ts_judge.sv
module ts_judge
  import ts_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       accept,
  input  logic [7:0] raw_byte,
  output logic       ts_received,
  output logic       ts_error,
  output logic       inverse_conv
);
  ts_conv_e verdict;
  assign verdict = classify_ts(raw_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_received  <= 1'b0;
      ts_error     <= 1'b0;
      inverse_conv <= 1'b0;
    end else if (clear) begin
      ts_received  <= 1'b0;
      ts_error     <= 1'b0;
      inverse_conv <= 1'b0;
    end else if (accept) begin
      ts_received  <= 1'b1;
      ts_error     <= (verdict == TS_INVALID);
      inverse_conv <= (verdict == TS_INVERSE);
    end
  end

  // R7: an error verdict always comes with a received character
  a_r7_error_needs_rcv: assert property (@(posedge clk) disable iff (!rst_n)
    ts_error |-> ts_received);

  // R6: inverse convention and error never hold together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts_error && inverse_conv));

  // R8: a judged character keeps its verdict until the next clear
  a_r8_verdict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ts_received) && !$past(clear)) |-> $stable({ts_received, ts_error, inverse_conv}));
endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
  parameter int EARLY_LIMIT = 400,
  parameter int LATE_LIMIT  = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       card_rst,
  input  logic       card_clk,
  input  logic       card_vdd,
  input  logic       io_term,
  input  logic       io_card,
  input  logic       char_done,
  input  logic [7:0] char_data,
  output logic       activated,
  output logic       ts_received,
  output logic       ts_error,
  output logic       atr_early,
  output logic       atr_late,
  output logic       inverse_conv
);
  localparam int NSIG = 4;

  logic io_line;
  logic [NSIG-1:0] raw_vec, sync_vec;
  logic released, clear, accept;

  assign io_line = io_term & io_card;
  assign raw_vec = {card_vdd, card_clk, card_rst, io_line};

  ts_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(raw_vec),
    .sync_out(sync_vec)
  );

  ts_window #(.EARLY_LIMIT(EARLY_LIMIT), .LATE_LIMIT(LATE_LIMIT)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .vdd_s    (sync_vec[3]),
    .cclk_s   (sync_vec[2]),
    .crst_s   (sync_vec[1]),
    .io_s     (sync_vec[0]),
    .ts_rcv   (ts_received),
    .activated(activated),
    .released (released),
    .clear    (clear),
    .atr_early(atr_early),
    .atr_late (atr_late)
  );

  assign accept = char_done & activated & released & ~ts_received & ~clear;

  ts_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clear),
    .accept      (accept),
    .raw_byte    (char_data),
    .ts_received (ts_received),
    .ts_error    (ts_error),
    .inverse_conv(inverse_conv)
  );

  // R1: no session flag can be up while the interface is inactive
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !activated |-> !(ts_received || atr_early || atr_late));

  // R10: a card reset edge leaves nothing judged in the next cycle
  a_r10_card_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !(ts_received || atr_early || atr_late));
endmodule

// File: tb/ts_checker_test.sv
module ts_checker_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_rst = 1'b0, card_clk = 1'b0, card_vdd = 1'b0;
  logic io_term = 1'b1, io_card = 1'b1;
  logic char_done = 1'b0;
  logic [7:0] char_data = 8'h00;
  logic activated, ts_received, ts_error, atr_early, atr_late, inverse_conv;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_checker uut (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .card_clk(card_clk),
    .card_vdd(card_vdd), .io_term(io_term), .io_card(io_card),
    .char_done(char_done), .char_data(char_data),
    .activated(activated), .ts_received(ts_received), .ts_error(ts_error),
    .atr_early(atr_early), .atr_late(atr_late), .inverse_conv(inverse_conv)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) card_clk = 1'b1;
      @(negedge clk) card_clk = 1'b0;
    end
    settle(6);
  endtask

  task automatic start_bit(input bit on_card_side);
    @(negedge clk);
    if (on_card_side) io_card = 1'b0; else io_term = 1'b0;
    settle(4);
    io_card = 1'b1; io_term = 1'b1;
    settle(6);
  endtask

  task automatic deliver(input logic [7:0] raw);
    @(negedge clk);
    char_data = raw; char_done = 1'b1;
    @(negedge clk);
    char_done = 1'b0;
    settle(4);
  endtask

  task automatic card_reset_cycle();
    @(negedge clk) card_rst = 1'b0;
    settle(6);
    @(negedge clk) card_rst = 1'b1;
    settle(6);
  endtask

  task automatic expect_flags(input string req, input logic rc, input logic er,
                              input logic ea, input logic la, input logic iv);
    check(req, "ts_received",  ts_received,  rc);
    check(req, "ts_error",     ts_error,     er);
    check(req, "atr_early",    atr_early,    ea);
    check(req, "atr_late",     atr_late,     la);
    check(req, "inverse_conv", inverse_conv, iv);
  endtask

  task automatic t_reset_state();
    settle(3);
    check("R10", "activated after reset", activated, 1'b0);
    expect_flags("R10", 0, 0, 0, 0, 0);
  endtask

  task automatic t_power_up();
    @(negedge clk) card_vdd = 1'b1;
    settle(6);
    check("R1", "activated before clock", activated, 1'b0);
    ticks(3);
    check("R1", "activated after clock", activated, 1'b1);
  endtask

  task automatic t_direct_early();
    @(negedge clk) card_rst = 1'b1;
    settle(6);
    ticks(300);
    start_bit(1'b0);            // R2: start seen through the terminal-side line
    deliver(8'h3B);
    expect_flags("R5", 1, 0, 1, 0, 0);
    check("R3", "early at 300", atr_early, 1'b1);
    ticks(500);
    start_bit(1'b1);
    deliver(8'h03);             // R8: second byte must be ignored
    expect_flags("R8", 1, 0, 1, 0, 0);
  endtask

  task automatic t_clear_then_inverse();
    @(negedge clk) card_rst = 1'b0;
    settle(6);
    expect_flags("R10", 0, 0, 0, 0, 0);
    check("R10", "activated kept", activated, 1'b1);
    @(negedge clk) card_rst = 1'b1;
    settle(6);
    ticks(1000);
    start_bit(1'b1);            // R2: start seen through the card-side line
    deliver(8'h03);
    expect_flags("R6", 1, 0, 0, 0, 1);
    check("R3", "not early at 1000", atr_early, 1'b0);
  endtask

  task automatic t_early_edges();
    card_reset_cycle();
    ticks(399);
    start_bit(1'b0);
    check("R3", "early at 399", atr_early, 1'b1);
    deliver(8'h55);
    expect_flags("R7", 1, 1, 1, 0, 0);
    card_reset_cycle();
    ticks(400);
    start_bit(1'b1);
    check("R3", "early at 400", atr_early, 1'b0);
    deliver(8'h3B);
    ticks(200);
    check("R9", "no late after receive", atr_late, 1'b0);
  endtask

  task automatic t_late();
    card_reset_cycle();
    ticks(39999);
    check("R4", "late at 39999", atr_late, 1'b0);
    ticks(1);
    check("R4", "late at 40000", atr_late, 1'b1);
    start_bit(1'b0);
    deliver(8'h3B);
    expect_flags("R4", 1, 0, 0, 1, 0);
  endtask

  task automatic t_power_down();
    @(negedge clk) card_vdd = 1'b0;
    settle(6);
    check("R1", "activated after supply loss", activated, 1'b0);
    expect_flags("R1", 0, 0, 0, 0, 0);
  endtask

  initial begin
    settle(3);
    rst_n = 1'b1;
    t_reset_state();
    t_power_up();
    t_direct_early();
    t_clear_then_inverse();
    t_early_edges();
    t_late();
    t_power_down();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule